// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host processor byte-wide access to packet buffer storage through a pointer register and a four-byte data window. The storage is split into pages, one per packet. The pointer word does three jobs at once. Its top bit chooses which page is used: either the page at the head of the receive queue or the page named by the packet-number register. Its low bits give the byte offset inside that page. Another bit chooses whether the pointer steps forward on each data access or stays where it is.

The receive-queue head and the packet number come from neighbouring logic and enter as plain inputs. The block holds the page storage itself as a synchronous RAM. It returns read data one cycle after each read strobe, together with a valid flag.

A host that reads or writes a 16-bit quantity issues two byte accesses at consecutive window lanes, low byte first. In stepping mode the pointer therefore advances twice.

Top module: `pdp_data_port`

## Requirements
- R1: After reset the pointer is 0x0000 and `bus_rvalid` is low; reading register offsets 6 and 7 returns 0x00.
- R2: A write at register offset 6 loads pointer bits 7:0 and a write at offset 7 loads pointer bits 15:8, each leaving the other byte unchanged. A read at offset 6 returns pointer bits 7:0.
- R3: A read at offset 7 returns pointer bits 15:8 with bit 11 forced to zero (mask 0xF7).
- R4: Pointer bit 15 set selects the page on `rx_head_pg`; clear selects the page on `pkt_num_pg`. Both inputs are sampled in the cycle of the data access.
- R5: With pointer bit 14 set, a data-window access at offsets 8 to 11 uses byte address pointer[10:0] whatever the lane. Afterwards pointer[10:0] increments modulo 2048 and bits 15:11 keep their value.
- R6: With pointer bit 14 clear, a data-window access uses byte address (pointer[10:0] + lane) modulo 2048, where lane = offset − 8. The pointer keeps its value.
- R7: Each read strobe is answered by `bus_rvalid` high for exactly one cycle, in the cycle after the strobe, with the data on `bus_rdata`. `bus_rvalid` stays low after writes and idle cycles.
- R8: A byte written through the window is returned by a later window read of the same page and byte address, and it does not appear in any other page.
- R9: Accesses at register offsets 0–5 and 12–15 change neither the pointer nor the page storage; reads there return 0x00 with `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_acc | input | 1 | Register access strobe, one byte per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | REG_W (4) | Register offset within the bank |
| bus_wdata | input | 8 | Write byte |
| rx_head_pg | input | log2(PAGES) (2) | Page at the head of the receive queue |
| pkt_num_pg | input | log2(PAGES) (2) | Page held in the packet-number register |
| bus_rdata | output | 8 | Read byte, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |

## Verification
The hardest cases to reach are the two 11-bit wraps. In stepping mode the offset 0x7FF must roll to 0x000 without carrying into the hidden bit 11. In fixed mode a lane offset added near the top of the page must fold back to the page start. The stimulus gets there by loading the pointer bytes directly. It then writes at the boundary and reads the byte back through a different mode and lane, and it inspects the pointer bytes, knowing that bit 11 never shows on readback. Page selection is exercised by swapping the queue-head and packet-number inputs between accesses to the same offset.

// File: rtl/pdp_pkg.sv
`timescale 1ns/1ps
package pdp_pkg;
   localparam int PTR_W        = 16;
   localparam int PTR_SRC_BIT  = 15;
   localparam int PTR_INC_BIT  = 14;
   localparam logic [7:0] PTR_HI_RD_MASK = 8'hF7;
   localparam int WIN_LANES    = 4;

   typedef enum logic [2:0] {
      ACC_OTHER,
      ACC_PTR_LO,
      ACC_PTR_HI,
      ACC_WIN
   } acc_kind_e;
endpackage

// File: rtl/pdp_ptr_reg.sv
`timescale 1ns/1ps
module pdp_ptr_reg
   import pdp_pkg::*;
#(
   parameter int OFS_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic             step,
   input  logic [7:0]       wdata,
   output logic [PTR_W-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (wr_lo) begin
         ptr[7:0] <= wdata;
      end else if (wr_hi) begin
         ptr[PTR_W-1:8] <= wdata;
      end else if (step) begin
         ptr[OFS_W-1:0] <= ptr[OFS_W-1:0] + OFS_W'(1);
      end
   end
endmodule

// File: rtl/pdp_addr_gen.sv
`timescale 1ns/1ps
module pdp_addr_gen #(
   parameter int OFS_W = 11,
   parameter int PG_W  = 2,
   parameter int LN_W  = 2
) (
   input  logic [OFS_W-1:0] ptr_ofs,
   input  logic             use_rx,
   input  logic             inc_mode,
   input  logic [LN_W-1:0]  lane,
   input  logic [PG_W-1:0]  rx_head_pg,
   input  logic [PG_W-1:0]  pkt_num_pg,
   output logic [PG_W-1:0]  page,
   output logic [OFS_W-1:0] ofs
);
   logic [OFS_W-1:0] lane_add;

   assign lane_add = inc_mode ? '0 : OFS_W'(lane);
   assign page     = use_rx ? rx_head_pg : pkt_num_pg;
   assign ofs      = ptr_ofs + lane_add;
endmodule

// File: rtl/pdp_page_ram.sv
`timescale 1ns/1ps
module pdp_page_ram #(
   parameter int PAGES      = 4,
   parameter int PAGE_BYTES = 2048,
   parameter int LANES      = 4
) (
   input  logic                          clk,
   input  logic                          we,
   input  logic                          re,
   input  logic [$clog2(PAGES)-1:0]      page,
   input  logic [$clog2(PAGE_BYTES)-1:0] ofs,
   input  logic [7:0]                    wdata,
   output logic [7:0]                    rbyte
);
   localparam int PG_W  = $clog2(PAGES);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int LN_W  = $clog2(LANES);
   localparam int WORDS = PAGES * PAGE_BYTES / LANES;
   localparam int IDX_W = PG_W + OFS_W - LN_W;

   logic [IDX_W-1:0]     idx;
   logic [LN_W-1:0]      lane_q;
   logic [LANES*8-1:0]   rd_all;

   assign idx = {page, ofs[OFS_W-1:LN_W]};

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] bank [WORDS];
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (we && ofs[LN_W-1:0] == LN_W'(b)) begin
            bank[idx] <= wdata;
         end
         if (re) begin
            q <= bank[idx];
         end
      end
      assign rd_all[8*b +: 8] = q;
   end

   always_ff @(posedge clk) begin
      if (re) begin
         lane_q <= ofs[LN_W-1:0];
      end
   end

   assign rbyte = rd_all[8*lane_q +: 8];
endmodule

// File: rtl/pdp_data_port.sv
`timescale 1ns/1ps
module pdp_data_port
   import pdp_pkg::*;
#(
   parameter int PAGES        = 4,
   parameter int PAGE_BYTES   = 2048,
   parameter int REG_W        = 4,
   parameter int REG_PTR_LO   = 6,
   parameter int REG_PTR_HI   = 7,
   parameter int REG_WIN_BASE = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          bus_acc,
   input  logic                          bus_wr,
   input  logic [REG_W-1:0]              bus_reg,
   input  logic [7:0]                    bus_wdata,
   input  logic [$clog2(PAGES)-1:0]      rx_head_pg,
   input  logic [$clog2(PAGES)-1:0]      pkt_num_pg,
   output logic [7:0]                    bus_rdata,
   output logic                          bus_rvalid
);
   localparam int PG_W  = $clog2(PAGES);
   localparam int OFS_W = $clog2(PAGE_BYTES);
   localparam int LN_W  = $clog2(WIN_LANES);

   if (PAGES < 2) begin : g_bad_pages
      $error("PAGES must be at least 2");
   end
   if ((1 << OFS_W) != PAGE_BYTES || OFS_W > 11 || OFS_W < 8) begin : g_bad_page_bytes
      $error("PAGE_BYTES must be a power of two from 256 to 2048");
   end
   if (REG_WIN_BASE % WIN_LANES != 0) begin : g_bad_win_base
      $error("REG_WIN_BASE must be aligned to the window width");
   end

   acc_kind_e        kind;
   logic             win_acc;
   logic [PTR_W-1:0] ptr_q;
   logic [PG_W-1:0]  page;
   logic [OFS_W-1:0] ofs;
   logic [7:0]       ram_byte;
   logic [7:0]       reg_rd_q;
   logic             from_ram_q;
   logic             rvalid_q;

   always_comb begin
      if ((bus_reg >> LN_W) == REG_W'(REG_WIN_BASE >> LN_W)) begin
         kind = ACC_WIN;
      end else if (bus_reg == REG_W'(REG_PTR_LO)) begin
         kind = ACC_PTR_LO;
      end else if (bus_reg == REG_W'(REG_PTR_HI)) begin
         kind = ACC_PTR_HI;
      end else begin
         kind = ACC_OTHER;
      end
   end

   assign win_acc = bus_acc && (kind == ACC_WIN);

   pdp_ptr_reg #(.OFS_W(OFS_W)) i_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (bus_acc && bus_wr && kind == ACC_PTR_LO),
      .wr_hi (bus_acc && bus_wr && kind == ACC_PTR_HI),
      .step  (win_acc && ptr_q[PTR_INC_BIT]),
      .wdata (bus_wdata),
      .ptr   (ptr_q)
   );

   pdp_addr_gen #(.OFS_W(OFS_W), .PG_W(PG_W), .LN_W(LN_W)) i_addr (
      .ptr_ofs    (ptr_q[OFS_W-1:0]),
      .use_rx     (ptr_q[PTR_SRC_BIT]),
      .inc_mode   (ptr_q[PTR_INC_BIT]),
      .lane       (bus_reg[LN_W-1:0]),
      .rx_head_pg (rx_head_pg),
      .pkt_num_pg (pkt_num_pg),
      .page       (page),
      .ofs        (ofs)
   );

   pdp_page_ram #(.PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .LANES(WIN_LANES)) i_ram (
      .clk   (clk),
      .we    (win_acc && bus_wr),
      .re    (win_acc && !bus_wr),
      .page  (page),
      .ofs   (ofs),
      .wdata (bus_wdata),
      .rbyte (ram_byte)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q   <= 1'b0;
         from_ram_q <= 1'b0;
         reg_rd_q   <= '0;
      end else begin
         rvalid_q <= bus_acc && !bus_wr;
         if (bus_acc && !bus_wr) begin
            from_ram_q <= (kind == ACC_WIN);
            case (kind)
               ACC_PTR_LO: reg_rd_q <= ptr_q[7:0];
               ACC_PTR_HI: reg_rd_q <= ptr_q[PTR_W-1:8] & PTR_HI_RD_MASK;
               default:    reg_rd_q <= '0;
            endcase
         end
      end
   end

   assign bus_rvalid = rvalid_q;
   assign bus_rdata  = from_ram_q ? ram_byte : reg_rd_q;
endmodule

// File: rtl/pdp_data_port_chk.sv
`timescale 1ns/1ps
module pdp_data_port_chk
   import pdp_pkg::*;
#(
   parameter int PAGE_BYTES   = 2048,
   parameter int REG_W        = 4,
   parameter int REG_PTR_LO   = 6,
   parameter int REG_PTR_HI   = 7,
   parameter int REG_WIN_BASE = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_acc,
   input logic             bus_wr,
   input logic [REG_W-1:0] bus_reg,
   input logic [7:0]       bus_rdata,
   input logic             bus_rvalid,
   input logic [PTR_W-1:0] ptr
);
   localparam int OFS_W = $clog2(PAGE_BYTES);

   logic in_win;
   logic in_other;
   assign in_win   = (bus_reg >> 2) == REG_W'(REG_WIN_BASE >> 2);
   assign in_other = !in_win && bus_reg != REG_W'(REG_PTR_LO) && bus_reg != REG_W'(REG_PTR_HI);

   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_acc && !bus_wr) |=> bus_rvalid);  // R7
   AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_acc && !bus_wr) |=> !bus_rvalid);  // R7
   AST_HI_BIT11_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_acc && !bus_wr && bus_reg == REG_W'(REG_PTR_HI)) |=> bus_rdata[3] == 1'b0);  // R3
   AST_FIXED_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_acc && in_win && !ptr[PTR_INC_BIT]) |=> $stable(ptr));  // R6
   AST_INC_OFS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_acc && in_win && ptr[PTR_INC_BIT]) |=>
         ptr[OFS_W-1:0] == OFS_W'($past(ptr[OFS_W-1:0]) + 1));  // R5
   AST_INC_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_acc && in_win && ptr[PTR_INC_BIT]) |=> ptr[PTR_W-1:OFS_W] == $past(ptr[PTR_W-1:OFS_W]));  // R5
   AST_OTHER_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_acc || in_other) |=> $stable(ptr));  // R9
endmodule

bind pdp_data_port pdp_data_port_chk #(
   .PAGE_BYTES   (PAGE_BYTES),
   .REG_W        (REG_W),
   .REG_PTR_LO   (REG_PTR_LO),
   .REG_PTR_HI   (REG_PTR_HI),
   .REG_WIN_BASE (REG_WIN_BASE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_acc    (bus_acc),
   .bus_wr     (bus_wr),
   .bus_reg    (bus_reg),
   .bus_rdata  (bus_rdata),
   .bus_rvalid (bus_rvalid),
   .ptr        (ptr_q)
);

// File: tb/test_pdp_data_port.sv
`timescale 1ns/1ps
module test_pdp_data_port;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_acc = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_reg = '0;
   logic [7:0] bus_wdata = '0;
   logic [1:0] rx_head_pg = 2'd1;
   logic [1:0] pkt_num_pg = 2'd2;
   logic [7:0] bus_rdata;
   logic       bus_rvalid;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   logic done = 1'b0;

   typedef struct {
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   logic [15:0] bm_ptr = '0;
   logic [7:0]  shadow [int];

   always #2 clk = ~clk;

   pdp_data_port i_pdp_data_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_acc    (bus_acc),
      .bus_wr     (bus_wr),
      .bus_reg    (bus_reg),
      .bus_wdata  (bus_wdata),
      .rx_head_pg (rx_head_pg),
      .pkt_num_pg (pkt_num_pg),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid)
   );

   function automatic int win_key(input logic [3:0] r);
      logic [1:0]  pg;
      logic [10:0] a;
      pg = bm_ptr[15] ? rx_head_pg : pkt_num_pg;
      a  = bm_ptr[14] ? bm_ptr[10:0] : bm_ptr[10:0] + 11'(r - 4'd8);
      return int'(pg) * 2048 + int'(a);
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic put(input logic [3:0] r, input logic [7:0] d);
      @(negedge clk);
      bus_acc = 1'b1; bus_wr = 1'b1; bus_reg = r; bus_wdata = d;
      if (r == 4'd6) bm_ptr[7:0] = d;
      else if (r == 4'd7) bm_ptr[15:8] = d;
      else if (r >= 4'd8 && r <= 4'd11) begin
         shadow[win_key(r)] = d;
         if (bm_ptr[14]) bm_ptr[10:0] = bm_ptr[10:0] + 11'd1;
      end
      @(negedge clk);
      bus_acc = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic get(input logic [3:0] r, input string tag);
      exp_t e;
      @(negedge clk);
      bus_acc = 1'b1; bus_wr = 1'b0; bus_reg = r;
      e.tag = tag;
      if (r == 4'd6) e.val = bm_ptr[7:0];
      else if (r == 4'd7) e.val = bm_ptr[15:8] & 8'hF7;
      else if (r >= 4'd8 && r <= 4'd11) begin
         e.val = shadow.exists(win_key(r)) ? shadow[win_key(r)] : 8'hxx;
         if (bm_ptr[14]) bm_ptr[10:0] = bm_ptr[10:0] + 11'd1;
      end else e.val = 8'h00;
      exp_q.push_back(e);
      @(negedge clk);
      bus_acc = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R7 unexpected rvalid actual=1 expected=0");
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(e.tag, bus_rdata, e.val);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<=20000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rvalid after reset", {7'd0, bus_rvalid}, 8'h00);
      get(4'd6, "R1 ptr lo reset");
      get(4'd7, "R1 ptr hi reset");

      put(4'd6, 8'h10); put(4'd7, 8'h40);
      get(4'd6, "R2 ptr lo readback");
      get(4'd7, "R2 ptr hi readback");

      for (int i = 0; i < 8; i++) put(4'(8 + (i % 4)), 8'(8'hA0 + i));
      get(4'd6, "R5 ptr stepped by 8");

      put(4'd6, 8'h10); put(4'd7, 8'h00);
      for (int l = 0; l < 4; l++) get(4'(8 + l), "R6 fixed lane read R8");
      get(4'd6, "R6 ptr lo unchanged");
      get(4'd7, "R6 ptr hi unchanged");

      put(4'd7, 8'hFF); get(4'd7, "R3 hi mask F7");
      put(4'd7, 8'h08); get(4'd7, "R3 bit11 hidden");

      put(4'd6, 8'hFF); put(4'd7, 8'h47);
      put(4'd10, 8'h5A);
      get(4'd6, "R5 offset wrap lo");
      get(4'd7, "R5 upper bits kept");
      put(4'd6, 8'hFF); put(4'd7, 8'h47);
      get(4'd8, "R5 read at 0x7FF");

      put(4'd6, 8'hFE); put(4'd7, 8'h07);
      put(4'd11, 8'h3C);
      get(4'd11, "R6 lane wrap read");
      put(4'd6, 8'h01); put(4'd7, 8'h40);
      get(4'd9, "R5 lane ignored");

      put(4'd6, 8'h10); put(4'd7, 8'h80);
      put(4'd8, 8'h11);
      get(4'd8, "R4 rx head page");
      put(4'd7, 8'h00);
      get(4'd8, "R4 packet page R8");
      @(negedge clk); pkt_num_pg = 2'd1; rx_head_pg = 2'd3;
      get(4'd8, "R4 packet page swapped");
      put(4'd7, 8'h80); put(4'd8, 8'h33);
      get(4'd8, "R4 rx page 3");
      @(negedge clk); rx_head_pg = 2'd1;
      get(4'd8, "R8 page 1 untouched");

      put(4'd0, 8'hFF); put(4'd12, 8'h55); put(4'd5, 8'h12);
      get(4'd6, "R9 ptr lo kept");
      get(4'd7, "R9 ptr hi kept");
      get(4'd3, "R9 other reads zero");
      get(4'd13, "R9 other reads zero");
      get(4'd8, "R9 storage kept");

      repeat (4) @(negedge clk);
      check("R7 all reads answered", 8'(exp_q.size()), 8'h00);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule